// File: doc/BRIEF.md
# Byte-Lane Mask, Extract and Insert Unit

This unit is one execution slice of a 64-bit integer datapath. It takes operand A, operand B and a 7-bit function code. It returns one of several results: a plain shift of A, or A with a byte-aligned field cleared, pulled out or placed at a byte offset. Paired low and high forms of each field operation let code work on a field that starts at any byte. The low form handles the part of the field that sits in the addressed quadword. The high form handles the part that spills into the next quadword. A byte-zap pair clears whole bytes of A under an eight-bit lane mask taken from B.

The unit takes one request per cycle when `in_valid` is high. The result, a valid strobe and an illegal-code flag are registered and appear one clock later. Memory access and the multi-instruction sequences that use these results belong to the surrounding pipeline.

Top module: `byte_lane_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` and `illegal` hold their values while no request arrives. Reset drives `out_valid`, `illegal` and `result` to zero.
- R2: Code 0x39 gives A shifted left logically by B[5:0].
- R3: Code 0x34 gives A shifted right logically by B[5:0]. Code 0x3c gives A shifted right arithmetically by B[5:0], replicating bit 63.
- R4: Mask-low codes 0x02, 0x12, 0x22 and 0x32 clear a field of 1, 2, 4 or 8 bytes in A. The field starts at byte offset B[2:0], and any field bytes above byte 7 are ignored.
- R5: Mask-high codes 0x52, 0x62 and 0x72 take a 2-, 4- or 8-byte field at offset B[2:0]. They clear the low bytes of A that match the field bytes lying beyond byte 7. At offset 0 the result equals A.
- R6: Extract-low codes 0x06, 0x16, 0x26 and 0x36 shift A right logically by 8·B[2:0]. They keep the low 1, 2, 4 or 8 bytes and zero the rest.
- R7: Extract-high codes 0x5a, 0x6a and 0x7a shift A left by (64 − 8·B[2:0]) mod 64. They keep the low 2, 4 or 8 bytes.
- R8: Insert-low codes 0x0b, 0x1b, 0x2b and 0x3b take the low 1, 2, 4 or 8 bytes of A and shift them left by 8·B[2:0]. Bits shifted past bit 63 are dropped.
- R9: Insert-high codes 0x57, 0x67 and 0x77 take the low 2, 4 or 8 bytes of A and shift them right by 64 − 8·B[2:0]. At offset 0 the result is zero.
- R10: Code 0x30 clears byte i of A for each i where B[i] is 1. Code 0x31 clears byte i where B[i] is 0. B[63:8] has no effect.
- R11: Any other code gives `illegal` = 1 and `result` = 0 in the output cycle. A listed code gives `illegal` = 0.
- R12: Shift codes ignore B[63:6], and all byte-field codes ignore B[63:3].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A (data) |
| opb | input | 64 | Operand B (shift amount, byte offset or lane mask) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered flag for an unsupported function code |

## Verification
On every cycle, the assertions check the one-cycle strobe timing and that the outputs hold between requests. They also check that an illegal code yields a zero result, and three corner identities: mask-high at offset 0 returns A, insert-high at offset 0 returns zero, and a full zap mask returns zero. The byte arithmetic of each code family, including fields that cross the quadword edge, the arithmetic sign fill and the ignored upper bits of B, shows only through the bench's table of vectors with hand-computed results.

// File: rtl/blu_pkg.sv
package blu_pkg;

  typedef enum logic [3:0] {
    CLS_SLL,
    CLS_SRL,
    CLS_SRA,
    CLS_MSK_LO,
    CLS_MSK_HI,
    CLS_EXT_LO,
    CLS_EXT_HI,
    CLS_INS_LO,
    CLS_INS_HI,
    CLS_ZAP,
    CLS_ZAP_KEEP,
    CLS_BAD
  } op_class_e;

  typedef struct packed {
    op_class_e  cls;
    logic [1:0] size_sel;  // field of 1 << size_sel bytes
  } op_dec_t;

  localparam logic [6:0] FN_SLL  = 7'h39;
  localparam logic [6:0] FN_SRL  = 7'h34;
  localparam logic [6:0] FN_SRA  = 7'h3c;
  localparam logic [6:0] FN_ZAP  = 7'h30;
  localparam logic [6:0] FN_ZAPN = 7'h31;

endpackage

// File: rtl/blu_decode.sv
module blu_decode
  import blu_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output op_dec_t           dec
);

  always_comb begin
    dec.size_sel = func[5:4];
    unique case (func)
      FN_SLL:                          dec.cls = CLS_SLL;
      FN_SRL:                          dec.cls = CLS_SRL;
      FN_SRA:                          dec.cls = CLS_SRA;
      7'h02, 7'h12, 7'h22, 7'h32:      dec.cls = CLS_MSK_LO;
      7'h52, 7'h62, 7'h72:             dec.cls = CLS_MSK_HI;
      7'h06, 7'h16, 7'h26, 7'h36:      dec.cls = CLS_EXT_LO;
      7'h5a, 7'h6a, 7'h7a:             dec.cls = CLS_EXT_HI;
      7'h0b, 7'h1b, 7'h2b, 7'h3b:      dec.cls = CLS_INS_LO;
      7'h57, 7'h67, 7'h77:             dec.cls = CLS_INS_HI;
      FN_ZAP:                          dec.cls = CLS_ZAP;
      FN_ZAPN:                         dec.cls = CLS_ZAP_KEEP;
      default:                         dec.cls = CLS_BAD;
    endcase
  end

endmodule

// File: rtl/blu_shifter.sv
module blu_shifter
  import blu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  op_class_e         cls,
  input  logic [DATA_W-1:0] opa,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] shout
);

  always_comb begin
    unique case (cls)
      CLS_SLL: shout = opa << shamt;
      CLS_SRA: shout = DATA_W'($signed(opa) >>> shamt);
      default: shout = opa >> shamt;
    endcase
  end

endmodule

// File: rtl/blu_bytefield.sv
module blu_bytefield
  import blu_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  op_dec_t           dec,
  input  logic [DATA_W-1:0] opa,
  input  logic [LANES-1:0]  lane_ctl,
  output logic [DATA_W-1:0] fout
);

  logic [OFF_W-1:0]    off;
  logic [SH_W-1:0]     boff;
  logic [SH_W-1:0]     hi_sh;
  logic [LANES-1:0]    size_lanes;
  logic [DATA_W-1:0]   fmask;
  logic [DATA_W-1:0]   zmask;
  logic [DATA_W-1:0]   afield;
  logic [2*DATA_W-1:0] mask_wide;
  logic [2*DATA_W-1:0] data_wide;

  assign off   = lane_ctl[OFF_W-1:0];
  assign boff  = {off, 3'b000};
  assign hi_sh = SH_W'(0) - boff;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      size_lanes[i] = (i < (32'd1 << dec.size_sel));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fmask[g*8 +: 8] = {8{size_lanes[g]}};
    assign zmask[g*8 +: 8] = {8{lane_ctl[g]}};
  end

  assign afield    = opa & fmask;
  assign mask_wide = {{DATA_W{1'b0}}, fmask} << boff;
  assign data_wide = {{DATA_W{1'b0}}, afield} << boff;

  always_comb begin
    unique case (dec.cls)
      CLS_MSK_LO:   fout = opa & ~mask_wide[DATA_W-1:0];
      CLS_MSK_HI:   fout = opa & ~mask_wide[2*DATA_W-1:DATA_W];
      CLS_EXT_LO:   fout = (opa >> boff) & fmask;
      CLS_EXT_HI:   fout = (opa << hi_sh) & fmask;
      CLS_INS_LO:   fout = data_wide[DATA_W-1:0];
      CLS_INS_HI:   fout = data_wide[2*DATA_W-1:DATA_W];
      CLS_ZAP:      fout = opa & ~zmask;
      CLS_ZAP_KEEP: fout = opa & zmask;
      default:      fout = '0;
    endcase
  end

endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import blu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7,
  localparam int LANES = DATA_W / 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  op_dec_t           dec;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] bf_res;
  logic [DATA_W-1:0] nxt_res;
  logic              is_shift;

  blu_decode #(.FUNC_W(FUNC_W)) u_dec (
    .func (func),
    .dec  (dec)
  );

  blu_shifter #(.DATA_W(DATA_W)) u_shift (
    .cls   (dec.cls),
    .opa   (opa),
    .shamt (opb[SH_W-1:0]),
    .shout (sh_res)
  );

  blu_bytefield #(.DATA_W(DATA_W)) u_field (
    .dec      (dec),
    .opa      (opa),
    .lane_ctl (opb[LANES-1:0]),
    .fout     (bf_res)
  );

  assign is_shift = (dec.cls == CLS_SLL) || (dec.cls == CLS_SRL) ||
                    (dec.cls == CLS_SRA);

  always_comb begin
    if (dec.cls == CLS_BAD) nxt_res = '0;
    else if (is_shift)      nxt_res = sh_res;
    else                    nxt_res = bf_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_res;
        illegal <= (dec.cls == CLS_BAD);
      end
    end
  end

endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [FUNC_W-1:0] func,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  // R1
  strobe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid && !rst) |-> ($stable(result) && $stable(illegal)));

  // R11
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));

  // R5
  mask_hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (func == 7'h72) && (opb[2:0] == 3'd0))
      |-> (result == $past(opa)));

  // R9
  ins_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (opb[2:0] == 3'd0) &&
          ((func == 7'h57) || (func == 7'h67) || (func == 7'h77)))
      |-> (result == '0));

  // R10
  zap_all_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (func == 7'h30) && (opb[7:0] == 8'hff))
      |-> (result == '0));

endmodule

bind byte_lane_unit blu_checker #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .func      (func),
  .opa       (opa),
  .opb       (opb),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/tb_byte_lane_unit.sv
module tb_byte_lane_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  func = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  byte_lane_unit dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .func      (func),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result),
    .illegal   (illegal)
  );

  typedef struct packed {
    logic [6:0]  fn;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] PAT = 64'h0123_4567_89ab_cdef;
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{7'h39, PAT, 64'd4, 64'h1234_5678_9abc_def0, 1'b0, 4'd2},               // R2
    '{7'h39, PAT, 64'h44, 64'h1234_5678_9abc_def0, 1'b0, 4'd12},             // R12
    '{7'h34, 64'h8000_0000_0000_0000, 64'd63, 64'h1, 1'b0, 4'd3},            // R3
    '{7'h3c, 64'h8000_0000_0000_0000, 64'd63, 64'hffff_ffff_ffff_ffff, 1'b0, 4'd3}, // R3
    '{7'h3c, 64'h7000_0000_0000_0000, 64'd4, 64'h0700_0000_0000_0000, 1'b0, 4'd3},  // R3
    '{7'h02, PAT, 64'd2, 64'h0123_4567_8900_cdef, 1'b0, 4'd4},               // R4
    '{7'h22, PAT, 64'd6, 64'h0000_4567_89ab_cdef, 1'b0, 4'd4},               // R4
    '{7'h52, PAT, 64'd7, 64'h0123_4567_89ab_cd00, 1'b0, 4'd5},               // R5
    '{7'h72, PAT, 64'd0, PAT, 1'b0, 4'd5},                                   // R5
    '{7'h72, PAT, 64'd3, 64'h0123_4567_8900_0000, 1'b0, 4'd5},               // R5
    '{7'h16, PAT, 64'd3, 64'h6789, 1'b0, 4'd6},                              // R6
    '{7'h36, PAT, 64'd9, 64'h0001_2345_6789_abcd, 1'b0, 4'd12},              // R12, R6
    '{7'h6a, PAT, 64'd5, 64'hef00_0000, 1'b0, 4'd7},                         // R7
    '{7'h7a, PAT, 64'd0, PAT, 1'b0, 4'd7},                                   // R7
    '{7'h0b, PAT, 64'd7, 64'hef00_0000_0000_0000, 1'b0, 4'd8},               // R8
    '{7'h2b, PAT, 64'd6, 64'hcdef_0000_0000_0000, 1'b0, 4'd8},               // R8
    '{7'h77, PAT, 64'd2, 64'h0123, 1'b0, 4'd9},                              // R9
    '{7'h67, PAT, 64'd6, 64'h89ab, 1'b0, 4'd9},                              // R9
    '{7'h57, PAT, 64'd0, 64'h0, 1'b0, 4'd9},                                 // R9
    '{7'h30, PAT, 64'h0f, 64'h0123_4567_0000_0000, 1'b0, 4'd10},             // R10
    '{7'h31, PAT, 64'h0f, 64'h0000_0000_89ab_cdef, 1'b0, 4'd10},             // R10
    '{7'h30, PAT, 64'h100, PAT, 1'b0, 4'd10},                                // R10
    '{7'h00, PAT, 64'd1, 64'h0, 1'b1, 4'd11},                                // R11
    '{7'h7f, PAT, 64'd1, 64'h0, 1'b1, 4'd11}                                 // R11
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    func = f; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset illegal", 64'(illegal), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].fn, VEC[i].a, VEC[i].b);
      chk($sformatf("R%0d vec%0d result", VEC[i].req, i), result, VEC[i].exp);
      chk($sformatf("R%0d vec%0d illegal", VEC[i].req, i), 64'(illegal), 64'(VEC[i].ill));
      chk($sformatf("R1 vec%0d out_valid", i), 64'(out_valid), 64'd1);
    end

    // R1 hold while idle: inputs change but no strobe
    apply(7'h31, PAT, 64'hf0);
    func = 7'h39; opa = 64'hffff; opb = 64'd1;
    @(negedge clk);
    chk("R1 idle out_valid", 64'(out_valid), 64'd0);
    chk("R1 idle result hold", result, 64'h0123_4567_0000_0000);
    chk("R1 idle illegal hold", 64'(illegal), 64'd0);

    // R1 back-to-back requests give results in consecutive cycles
    @(negedge clk);
    func = 7'h39; opa = 64'h1; opb = 64'd8; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 back1 result", result, 64'h100);
    func = 7'h34; opa = 64'hff00; opb = 64'd8;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 back2 result", result, 64'hff);
    chk("R1 back2 out_valid", 64'(out_valid), 64'd1);

    // R11 illegal flag sticks while idle, clears on a legal request
    apply(7'h45, PAT, 64'd0);
    @(negedge clk);
    chk("R11 illegal held", 64'(illegal), 64'd1);
    apply(7'h06, PAT, 64'h0000_0000_0000_0f00);
    chk("R12 extbl ignores B upper", result, 64'hef);
    chk("R11 illegal cleared", 64'(illegal), 64'd0);

    // R1 reset after activity clears outputs
    apply(7'h3b, PAT, 64'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset result", result, 64'd0);
    chk("R1 mid reset out_valid", 64'(out_valid), 64'd0);

    finish_run();
  end

endmodule